// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each of its two ALU operands must come from. It compares the instruction's two source register indices with the destination indices of the two older instructions still in flight. One is in the memory stage and one is in the write-back stage. A dependent instruction can then use a result in the cycle right after that result was produced, without waiting for it to reach the register file.

The decision logic is combinational and sits just before the ALU. A small wrapper holds the three pipeline registers that carry the indices, the write-enable bits and the data. In front of each ALU input there is a three-way multiplexer. The register file, stall generation and branch handling are outside the block. The ALU result of the execute stage comes in as a port, and the data path passes it on down the pipeline.

Top module: `opfwd_stage`

## Requirements
- R1: While reset is held, and until the first instruction is clocked in, both select outputs are 2'b00 and both ALU operand outputs are zero.
- R2: If an operand's source index matches the destination of the instruction one position older (the memory stage), and that producer writes a nonzero register, the select is 2'b10 and the operand equals the execute-stage result presented one cycle earlier.
- R3: If only the instruction two positions older (the write-back stage) matches under the same conditions, the select is 2'b01 and the operand equals the execute-stage result presented two cycles earlier.
- R4: When both older instructions match the same source index, the one-position-older result wins (select 2'b10).
- R5: With no qualifying match, the select is 2'b00 and the operand is the register-file value that was supplied with the instruction at decode.
- R6: A producer whose register-write bit is clear never causes forwarding.
- R7: A destination index of 0 never causes forwarding, whether or not its write bit is set.
- R8: The two operands are resolved independently. Each can take a different source in the same cycle, and both can take the same one.
- R9: An instruction decoded one cycle after the write enters execute one cycle later. It and the next two consumers of that register see selects 2'b10, 2'b01 and 2'b00 in turn. The third consumer relies on the register file doing its write before its read.
- R10: A select output never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| id_src_a | input | 5 | First source register index of the decoding instruction |
| id_src_b | input | 5 | Second source register index of the decoding instruction |
| id_dst | input | 5 | Destination register index of the decoding instruction |
| id_wr_en | input | 1 | Register-write control bit of the decoding instruction |
| id_val_a | input | DATA_W | Register-file read value for the first source |
| id_val_b | input | DATA_W | Register-file read value for the second source |
| ex_result | input | DATA_W | ALU result of the instruction currently in execute |
| fwd_sel_a | output | 2 | Source select for ALU operand A (00 file, 10 memory stage, 01 write-back stage) |
| fwd_sel_b | output | 2 | Source select for ALU operand B, same encoding |
| alu_in_a | output | DATA_W | Selected value for ALU operand A |
| alu_in_b | output | DATA_W | Selected value for ALU operand B |

## Verification
On every cycle the assertions tie each select code to port history. A 2'b10 select must carry the execute result from one cycle back, and the producer decoded two cycles back must have matched with its write bit set. A 2'b01 select must carry the result from two cycles back, and the producer from three cycles back must have matched while the younger one did not. The assertions also rule out forwarding of register 0 and the code 2'b11. The bench alone shows the cases where forwarding must not happen: a producer with its write bit clear, a consumer three positions after its producer, and both operands resolving to different stages at once. For these it uses directed sequences plus a long run of random instructions over a few registers, checked against a queue model.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam int IDX_W = 5;

  typedef logic [1:0] fwd_sel_t;

  localparam fwd_sel_t SEL_RF  = 2'b00;
  localparam fwd_sel_t SEL_EXM = 2'b10;
  localparam fwd_sel_t SEL_MWB = 2'b01;

  // A producer qualifies only if it writes, targets a real register and matches.
  function automatic logic producer_hits(input logic wr,
                                         input logic [IDX_W-1:0] dst,
                                         input logic [IDX_W-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  // Younger stage first.
  function automatic fwd_sel_t pick_sel(input logic hit_exm, input logic hit_mwb);
    if (hit_exm)      return SEL_EXM;
    else if (hit_mwb) return SEL_MWB;
    else              return SEL_RF;
  endfunction
endpackage

// File: rtl/opfwd_pipe_regs.sv
module opfwd_pipe_regs
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  id_src_a,
  input  logic [IDX_W-1:0]  id_src_b,
  input  logic [IDX_W-1:0]  id_dst,
  input  logic              id_wr_en,
  input  logic [DATA_W-1:0] id_val_a,
  input  logic [DATA_W-1:0] id_val_b,
  input  logic [DATA_W-1:0] ex_result,
  output logic [IDX_W-1:0]  ex_src_a,
  output logic [IDX_W-1:0]  ex_src_b,
  output logic [DATA_W-1:0] ex_val_a,
  output logic [DATA_W-1:0] ex_val_b,
  output logic [IDX_W-1:0]  exm_dst,
  output logic              exm_wr,
  output logic [DATA_W-1:0] exm_data,
  output logic [IDX_W-1:0]  mwb_dst,
  output logic              mwb_wr,
  output logic [DATA_W-1:0] mwb_data
);
  logic [IDX_W-1:0] ex_dst;
  logic             ex_wr;

  // Decode -> execute: all three indices travel on.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_src_a <= '0;
      ex_src_b <= '0;
      ex_dst   <= '0;
      ex_wr    <= 1'b0;
      ex_val_a <= '0;
      ex_val_b <= '0;
    end else begin
      ex_src_a <= id_src_a;
      ex_src_b <= id_src_b;
      ex_dst   <= id_dst;
      ex_wr    <= id_wr_en;
      ex_val_a <= id_val_a;
      ex_val_b <= id_val_b;
    end
  end

  // Execute -> memory -> write-back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exm_dst  <= '0;
      exm_wr   <= 1'b0;
      exm_data <= '0;
      mwb_dst  <= '0;
      mwb_wr   <= 1'b0;
      mwb_data <= '0;
    end else begin
      exm_dst  <= ex_dst;
      exm_wr   <= ex_wr;
      exm_data <= ex_result;
      mwb_dst  <= exm_dst;
      mwb_wr   <= exm_wr;
      mwb_data <= exm_data;
    end
  end
endmodule

// File: rtl/opfwd_detect.sv
module opfwd_detect
  import opfwd_pkg::*;
(
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] exm_dst,
  input  logic             exm_wr,
  input  logic [IDX_W-1:0] mwb_dst,
  input  logic             mwb_wr,
  output fwd_sel_t         sel
);
  logic hit_exm;
  logic hit_mwb;

  assign hit_exm = producer_hits(exm_wr, exm_dst, src);
  assign hit_mwb = producer_hits(mwb_wr, mwb_dst, src);
  assign sel     = pick_sel(hit_exm, hit_mwb);
endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_t          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] out
);
  always_comb begin
    unique case (sel)
      SEL_EXM: out = exm_val;
      SEL_MWB: out = mwb_val;
      default: out = rf_val;
    endcase
  end
endmodule

// File: rtl/opfwd_stage.sv
module opfwd_stage
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  id_src_a,
  input  logic [IDX_W-1:0]  id_src_b,
  input  logic [IDX_W-1:0]  id_dst,
  input  logic              id_wr_en,
  input  logic [DATA_W-1:0] id_val_a,
  input  logic [DATA_W-1:0] id_val_b,
  input  logic [DATA_W-1:0] ex_result,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic [DATA_W-1:0] alu_in_a,
  output logic [DATA_W-1:0] alu_in_b
);
  localparam int N_OPND = 2;

  logic [IDX_W-1:0]  ex_src_a, ex_src_b;
  logic [DATA_W-1:0] ex_val_a, ex_val_b;
  logic [IDX_W-1:0]  exm_dst, mwb_dst;
  logic              exm_wr, mwb_wr;
  logic [DATA_W-1:0] exm_data, mwb_data;

  logic [IDX_W-1:0]  opnd_src [N_OPND];
  logic [DATA_W-1:0] opnd_rf  [N_OPND];
  fwd_sel_t          opnd_sel [N_OPND];
  logic [DATA_W-1:0] opnd_out [N_OPND];

  opfwd_pipe_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .id_wr_en(id_wr_en), .id_val_a(id_val_a), .id_val_b(id_val_b),
    .ex_result(ex_result),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_val_a(ex_val_a), .ex_val_b(ex_val_b),
    .exm_dst(exm_dst), .exm_wr(exm_wr), .exm_data(exm_data),
    .mwb_dst(mwb_dst), .mwb_wr(mwb_wr), .mwb_data(mwb_data)
  );

  assign opnd_src[0] = ex_src_a;
  assign opnd_src[1] = ex_src_b;
  assign opnd_rf[0]  = ex_val_a;
  assign opnd_rf[1]  = ex_val_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    opfwd_detect det_i (
      .src(opnd_src[g]),
      .exm_dst(exm_dst), .exm_wr(exm_wr),
      .mwb_dst(mwb_dst), .mwb_wr(mwb_wr),
      .sel(opnd_sel[g])
    );
    opfwd_mux #(.DATA_W(DATA_W)) mux_i (
      .sel(opnd_sel[g]),
      .rf_val(opnd_rf[g]),
      .exm_val(exm_data),
      .mwb_val(mwb_data),
      .out(opnd_out[g])
    );
  end

  assign fwd_sel_a = opnd_sel[0];
  assign fwd_sel_b = opnd_sel[1];
  assign alu_in_a  = opnd_out[0];
  assign alu_in_b  = opnd_out[1];
endmodule

// File: rtl/opfwd_stage_chk.sv
module opfwd_stage_chk
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  id_src_a,
  input logic [IDX_W-1:0]  id_src_b,
  input logic [IDX_W-1:0]  id_dst,
  input logic              id_wr_en,
  input logic [DATA_W-1:0] id_val_a,
  input logic [DATA_W-1:0] id_val_b,
  input logic [DATA_W-1:0] ex_result,
  input logic [1:0]        fwd_sel_a,
  input logic [1:0]        fwd_sel_b,
  input logic [DATA_W-1:0] alu_in_a,
  input logic [DATA_W-1:0] alu_in_b
);
  // R2: memory-stage pick carries last cycle's result and a qualifying producer
  a_r2_exm_value_a: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_a == SEL_EXM |-> alu_in_a == $past(ex_result));
  a_r2_exm_value_b: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_b == SEL_EXM |-> alu_in_b == $past(ex_result));
  a_r2_exm_producer_a: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_a == SEL_EXM |-> ($past(id_wr_en, 2) && $past(id_dst, 2) == $past(id_src_a)));

  // R3: write-back pick carries the result from two cycles back
  a_r3_mwb_value_a: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_a == SEL_MWB |-> alu_in_a == $past(ex_result, 2));
  a_r3_mwb_value_b: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_b == SEL_MWB |-> alu_in_b == $past(ex_result, 2));
  a_r3_mwb_producer_b: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_b == SEL_MWB |-> ($past(id_wr_en, 3) && $past(id_dst, 3) == $past(id_src_b)));

  // R4: write-back pick only when the younger producer did not qualify
  a_r4_younger_first_a: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_a == SEL_MWB |->
      !($past(id_wr_en, 2) && $past(id_dst, 2) != '0 && $past(id_dst, 2) == $past(id_src_a)));

  // R5: file pick returns the value supplied at decode
  a_r5_rf_value_a: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_a == SEL_RF |-> alu_in_a == $past(id_val_a));
  a_r5_rf_value_b: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_b == SEL_RF |-> alu_in_b == $past(id_val_b));

  // R7: register 0 is never a forwarding source
  a_r7_no_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_a != SEL_RF |-> $past(id_src_a) != '0);
  a_r7_no_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel_b != SEL_RF |-> $past(id_src_b) != '0);

  // R10: only legal codes
  a_r10_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_sel_a) && $onehot0(fwd_sel_b));
endmodule

bind opfwd_stage opfwd_stage_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
  .id_wr_en(id_wr_en), .id_val_a(id_val_a), .id_val_b(id_val_b),
  .ex_result(ex_result),
  .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
  .alu_in_a(alu_in_a), .alu_in_b(alu_in_b)
);

// File: tb/opfwd_stage_tb_top.sv
module opfwd_stage_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    id_src_a = '0, id_src_b = '0, id_dst = '0;
  logic          id_wr_en = 1'b0;
  logic [DW-1:0] id_val_a = '0, id_val_b = '0, ex_result = '0;
  logic [1:0]    fwd_sel_a, fwd_sel_b;
  logic [DW-1:0] alu_in_a, alu_in_b;

  int n_checks = 0;
  int n_fail   = 0;
  int n_issued = 0;
  logic [1:0] last_sel_a, last_sel_b;

  typedef struct {
    int          sa, sb, d;
    bit          we;
    logic [31:0] va, vb, res;
  } ins_t;
  ins_t flight[$];

  always #10 clk = ~clk;

  opfwd_stage #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .id_wr_en(id_wr_en), .id_val_a(id_val_a), .id_val_b(id_val_b),
    .ex_result(ex_result),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .alu_in_a(alu_in_a), .alu_in_b(alu_in_b)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: look back through older in-flight instructions, nearest first.
  task automatic predict(input int src, input logic [31:0] rfv,
                         output logic [1:0] s, output logic [31:0] v, output string tag);
    int hits = 0;
    s = 2'b00; v = rfv; tag = "R5";
    for (int age = 1; age <= 2; age++) begin
      ins_t p = flight[flight.size() - 1 - age];
      if (p.d == src && !p.we && src != 0) tag = "R6";
      if (p.d == src && src == 0 && p.we) tag = "R7";
      if (p.we && p.d != 0 && p.d == src) begin
        hits++;
        if (hits == 1) begin
          s   = (age == 1) ? 2'b10 : 2'b01;
          v   = p.res;
          tag = (age == 1) ? "R2" : "R3";
        end else tag = "R4";
      end
    end
  endtask

  task automatic issue(input int sa, input int sb, input int d, input bit we,
                       input logic [31:0] va, input logic [31:0] vb);
    ins_t n;
    logic [1:0] es;
    logic [31:0] ev;
    string tag;
    id_src_a = sa[4:0]; id_src_b = sb[4:0]; id_dst = d[4:0];
    id_wr_en = we; id_val_a = va; id_val_b = vb;
    @(posedge clk);
    n.sa = sa; n.sb = sb; n.d = d; n.we = we; n.va = va; n.vb = vb;
    n.res = 32'h5EED_0000 + n_issued;
    n_issued++;
    flight.push_back(n);
    if (flight.size() > 3) void'(flight.pop_front());
    @(negedge clk);
    ex_result = flight[flight.size()-1].res;
    #1;
    predict(sa, va, es, ev, tag);
    check({tag, " operand A"}, {fwd_sel_a, alu_in_a}, {es, ev});
    predict(sb, vb, es, ev, tag);
    check({tag, " operand B"}, {fwd_sel_b, alu_in_b}, {es, ev});
    check("R10 legal codes", {62'd0, fwd_sel_a == 2'b11 || fwd_sel_b == 2'b11}, 64'd0);
    last_sel_a = fwd_sel_a;
    last_sel_b = fwd_sel_b;
  endtask

  task automatic bubble();
    issue(0, 0, 0, 1'b0, 32'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      ins_t b;
      b.sa = 0; b.sb = 0; b.d = 0; b.we = 0; b.va = 0; b.vb = 0; b.res = 0;
      flight.push_back(b);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sel A", {62'd0, fwd_sel_a}, 64'd0);
    check("R1 sel B", {62'd0, fwd_sel_b}, 64'd0);
    check("R1 alu A", {32'd0, alu_in_a}, 64'd0);
    check("R1 alu B", {32'd0, alu_in_b}, 64'd0);
    rst_n = 1'b1;
    #1;
    check("R1 after release", {60'd0, fwd_sel_a, fwd_sel_b}, 64'd0);

    // R9: producer then three consumers of r1
    issue(2, 3, 1, 1'b1, 32'h22, 32'h33);
    issue(1, 3, 4, 1'b1, 32'hBAD1, 32'h33);
    check("R9 second instr selects memory stage", {62'd0, last_sel_a}, 64'd2);
    issue(1, 7, 6, 1'b1, 32'hBAD2, 32'h77);
    check("R9 third instr selects write-back", {62'd0, last_sel_a}, 64'd1);
    issue(1, 9, 8, 1'b1, 32'h1111, 32'h99);
    check("R9 fourth instr uses register file", {62'd0, last_sel_a}, 64'd0);

    // R4: both older stages write r3
    bubble(); bubble();
    issue(0, 0, 3, 1'b1, 0, 0);
    issue(0, 0, 3, 1'b1, 0, 0);
    issue(3, 0, 10, 1'b1, 32'hAAAA, 32'h0);
    check("R4 younger producer wins", {62'd0, last_sel_a}, 64'd2);

    // R8: two producers feeding opposite operands, then same source on both
    bubble(); bubble();
    issue(0, 0, 5, 1'b1, 0, 0);
    issue(0, 0, 6, 1'b1, 0, 0);
    issue(6, 5, 11, 1'b1, 32'h6, 32'h5);
    check("R8 mixed sources", {60'd0, last_sel_a, last_sel_b}, 64'b1001);
    issue(11, 11, 12, 1'b1, 32'h1, 32'h2);
    check("R8 same source both", {60'd0, last_sel_a, last_sel_b}, 64'b1010);

    // R6: non-writing producer
    bubble(); bubble();
    issue(0, 0, 4, 1'b0, 0, 0);
    issue(4, 4, 13, 1'b1, 32'h4444, 32'h4545);
    check("R6 no write no forward", {60'd0, last_sel_a, last_sel_b}, 64'd0);

    // R7: writes to register 0 are never forwarded
    bubble(); bubble();
    issue(0, 0, 0, 1'b1, 0, 0);
    issue(0, 0, 0, 1'b1, 32'h7070, 32'h7171);
    check("R7 zero register not forwarded", {60'd0, last_sel_a, last_sel_b}, 64'd0);

    // Random stream over a few registers
    for (int i = 0; i < 400; i++) begin
      issue($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom_range(0, 1)), $urandom, $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule